// File: doc/BRIEF.md
# ADC Result Accumulation and Low-Pass Filter

This block sits after an analog-to-digital converter and reworks its stream of results. Each conversion result arrives as a sample word with a one-cycle valid strobe. A separate start-of-conversion strobe marks the moment a new conversion begins. A small control word, loaded through a write strobe, picks one of five processing modes. It also sets a right-shift amount, selects the source of the previous-sample copy, and can request a one-shot accumulator clear.

The modes are:

- **Basic pass-through:** the filtered output simply follows the incoming sample.
- **Running accumulate:** every sample is added to the accumulator, and the shifted sum is published on each sample.
- **Average and burst average:** a programmable number of samples is summed, the result is divided by a power of two, and the accumulator then restarts.
- **First-order low-pass filter:** the time constant is a power of two and the DC gain is unity.

At every start of conversion, either the raw result or the filtered result is saved into a previous-sample register. A neighbouring comparator can then use that register for difference measurements. For an average to be a true mean, software sets the repeat count equal to two raised to the shift amount.

Top module: `adc_accum_filter`

## Requirements
- R1: After reset every output is zero and the mode is basic pass-through.
- R2: In mode 000, and in reserved modes 101, 110 and 111, each valid sample is copied zero-extended to `filt_o` whatever the shift value; accumulator, counter and overflow flag do not change.
- R3: In mode 001, each valid sample is added to the accumulator and `filt_o` takes the new sum shifted right by the shift field at the same edge; the counter counts samples and sticks at its all-ones value.
- R4: In mode 010, samples are added and counted; on the sample that brings the counter to `rpt_count`, `filt_o` takes the sum shifted right and both the accumulator and the counter return to zero; on other samples `filt_o` holds.
- R5: Mode 011 behaves as mode 010, except that a sample arriving while the counter is zero replaces the accumulator content instead of adding to it.
- R6: In mode 100, each valid sample sets acc to acc + sample - (acc >> shift) and `filt_o` to the new acc >> shift; the counter is untouched, and a constant input settles with `filt_o` equal to that input.
- R7: A carry out of the ACC_W-bit accumulator sets `ovf_o`, which then stays set through mode changes until a clear; the accumulator keeps the low ACC_W bits.
- R8: A control write with `cfg_clr` high raises `clr_busy_o` for the next cycle; at the edge that ends that cycle the accumulator, counter and overflow flag become zero, any sample at that edge is not accumulated, and `filt_o` holds.
- R9: On `soc`, `prev_o` loads `filt_o` when the stored select bit is 1 and the zero-extended raw result `res_o` when it is 0, both as they stood before that edge; without `soc` it holds.
- R10: Mode, shift and select values written with `cfg_wr` apply only to samples at later edges, and a mode change by itself clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soc | input | 1 | Start-of-conversion strobe |
| res_valid | input | 1 | Conversion result valid strobe |
| res_data | input | SAMPLE_W | Conversion result word |
| cfg_wr | input | 1 | Loads the control fields below |
| cfg_mode | input | 3 | Processing mode code |
| cfg_shift | input | 3 | Right-shift amount (1 to 6 meaningful) |
| cfg_psel | input | 1 | Previous-sample source: 1 filtered, 0 raw |
| cfg_clr | input | 1 | Accumulator clear request, sampled with cfg_wr |
| rpt_count | input | CNT_W | Samples per average |
| acc_o | output | ACC_W | Accumulator |
| cnt_o | output | CNT_W | Sample counter |
| ovf_o | output | 1 | Sticky accumulator overflow |
| filt_o | output | ACC_W | Filtered result |
| res_o | output | SAMPLE_W | Last raw result |
| prev_o | output | ACC_W | Previous-sample register |
| clr_busy_o | output | 1 | Clear in progress, reads back as the clear bit |

## Verification
The bench keeps the 12-bit sample and 18-bit accumulator defaults, so about 65 full-scale samples are enough to carry out of the accumulator and reach the sticky overflow flag. It narrows CNT_W to 4, which brings counter saturation in accumulate mode within a handful of samples. A shift of 3 lets the low-pass filter settle within a few hundred samples. Switching straight from the filter into the average and burst modes leaves a nonzero accumulator with a zero counter, and that state shows the difference between the two averaging rules.

// File: rtl/adc_af_pkg.sv
package adc_af_pkg;

  localparam logic [2:0] MD_BASIC = 3'd0;
  localparam logic [2:0] MD_ACCUM = 3'd1;
  localparam logic [2:0] MD_AVG   = 3'd2;
  localparam logic [2:0] MD_BURST = 3'd3;
  localparam logic [2:0] MD_LPF   = 3'd4;

  typedef struct packed {
    logic [2:0] mode;
    logic [2:0] shift;
    logic       psel;
  } af_cfg_t;

endpackage

// File: rtl/adc_af_ctrl.sv
module adc_af_ctrl
  import adc_af_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_mode,
  input  logic [2:0] cfg_shift,
  input  logic       cfg_psel,
  input  logic       cfg_clr,
  output af_cfg_t    cfg_o,
  output logic       clr_busy_o
);

  af_cfg_t cfg_q;
  logic    clr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      clr_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        cfg_q.mode  <= cfg_mode;
        cfg_q.shift <= cfg_shift;
        cfg_q.psel  <= cfg_psel;
      end
      // the clear request lives exactly one cycle unless re-requested
      clr_q <= cfg_wr & cfg_clr;
    end
  end

  assign cfg_o      = cfg_q;
  assign clr_busy_o = clr_q;

endmodule

// File: rtl/adc_af_accum.sv
module adc_af_accum
  import adc_af_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 18,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  af_cfg_t             cfg,
  input  logic                clr_busy,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [CNT_W-1:0]    rpt_count,
  output logic [ACC_W-1:0]    acc_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                ovf_o,
  output logic [ACC_W-1:0]    filt_o
);

  localparam int PAD_W = ACC_W - SAMPLE_W;
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_n, filt_q, filt_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ovf_q, ovf_n;

  logic [ACC_W-1:0] ext, base, leak, wrapped;
  logic [SUM_W-1:0] sum, lpf_full;
  logic [CNT_W-1:0] cnt_inc, cnt_sat;
  logic             done;

  assign ext     = {{PAD_W{1'b0}}, smp_data};
  // burst mode restarts from the sample itself when no burst is open
  assign base    = (cfg.mode == MD_BURST && cnt_q == '0) ? '0 : acc_q;
  assign sum     = {1'b0, base} + {1'b0, ext};
  assign wrapped = sum[ACC_W-1:0];
  assign leak    = acc_q >> cfg.shift;
  assign lpf_full = {1'b0, acc_q} + {1'b0, ext} - {1'b0, leak};
  assign cnt_inc = cnt_q + 1'b1;
  assign cnt_sat = (&cnt_q) ? cnt_q : cnt_inc;
  assign done    = (cnt_inc == rpt_count);

  always_comb begin
    acc_n  = acc_q;
    cnt_n  = cnt_q;
    ovf_n  = ovf_q;
    filt_n = filt_q;
    if (clr_busy) begin
      acc_n = '0;
      cnt_n = '0;
      ovf_n = 1'b0;
    end else if (smp_valid) begin
      unique case (cfg.mode)
        MD_ACCUM: begin
          acc_n  = wrapped;
          ovf_n  = ovf_q | sum[ACC_W];
          cnt_n  = cnt_sat;
          filt_n = wrapped >> cfg.shift;
        end
        MD_AVG, MD_BURST: begin
          ovf_n = ovf_q | sum[ACC_W];
          if (done) begin
            filt_n = wrapped >> cfg.shift;
            acc_n  = '0;
            cnt_n  = '0;
          end else begin
            acc_n = wrapped;
            cnt_n = cnt_inc;
          end
        end
        MD_LPF: begin
          acc_n  = lpf_full[ACC_W-1:0];
          ovf_n  = ovf_q | lpf_full[ACC_W];
          filt_n = lpf_full[ACC_W-1:0] >> cfg.shift;
        end
        default: begin
          filt_n = ext;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      filt_q <= '0;
    end else begin
      acc_q  <= acc_n;
      cnt_q  <= cnt_n;
      ovf_q  <= ovf_n;
      filt_q <= filt_n;
    end
  end

  assign acc_o  = acc_q;
  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign filt_o = filt_q;

endmodule

// File: rtl/adc_af_hist.sv
module adc_af_hist #(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                soc,
  input  logic                psel,
  input  logic [ACC_W-1:0]    filt,
  output logic [SAMPLE_W-1:0] res_o,
  output logic [ACC_W-1:0]    prev_o
);

  localparam int PAD_W = ACC_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] res_q;
  logic [ACC_W-1:0]    prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      prev_q <= '0;
    end else begin
      if (smp_valid) res_q <= smp_data;
      if (soc) prev_q <= psel ? filt : {{PAD_W{1'b0}}, res_q};
    end
  end

  assign res_o  = res_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/adc_accum_filter.sv
module adc_accum_filter
  import adc_af_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 18,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                soc,
  input  logic                res_valid,
  input  logic [SAMPLE_W-1:0] res_data,
  input  logic                cfg_wr,
  input  logic [2:0]          cfg_mode,
  input  logic [2:0]          cfg_shift,
  input  logic                cfg_psel,
  input  logic                cfg_clr,
  input  logic [CNT_W-1:0]    rpt_count,
  output logic [ACC_W-1:0]    acc_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                ovf_o,
  output logic [ACC_W-1:0]    filt_o,
  output logic [SAMPLE_W-1:0] res_o,
  output logic [ACC_W-1:0]    prev_o,
  output logic                clr_busy_o
);

  af_cfg_t    cfg;
  logic       clr_busy;
  logic [2:0] mode_q;
  logic       psel_q;

  adc_af_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_mode   (cfg_mode),
    .cfg_shift  (cfg_shift),
    .cfg_psel   (cfg_psel),
    .cfg_clr    (cfg_clr),
    .cfg_o      (cfg),
    .clr_busy_o (clr_busy)
  );

  adc_af_accum #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W),
    .CNT_W    (CNT_W)
  ) u_accum (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .clr_busy  (clr_busy),
    .smp_valid (res_valid),
    .smp_data  (res_data),
    .rpt_count (rpt_count),
    .acc_o     (acc_o),
    .cnt_o     (cnt_o),
    .ovf_o     (ovf_o),
    .filt_o    (filt_o)
  );

  adc_af_hist #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W)
  ) u_hist (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (res_valid),
    .smp_data  (res_data),
    .soc       (soc),
    .psel      (cfg.psel),
    .filt      (filt_o),
    .res_o     (res_o),
    .prev_o    (prev_o)
  );

  assign mode_q     = cfg.mode;
  assign psel_q     = cfg.psel;
  assign clr_busy_o = clr_busy;

endmodule

// File: rtl/adc_af_checker.sv
module adc_af_checker
  import adc_af_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 18,
  parameter int CNT_W    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                soc,
  input logic                res_valid,
  input logic [2:0]          mode_q,
  input logic                psel_q,
  input logic                clr_busy,
  input logic [ACC_W-1:0]    acc,
  input logic [CNT_W-1:0]    cnt,
  input logic                ovf,
  input logic [ACC_W-1:0]    filt,
  input logic [SAMPLE_W-1:0] res,
  input logic [ACC_W-1:0]    prev
);

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr_busy |=> (acc == '0 && cnt == '0 && !ovf)); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_busy) |=> ovf); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!res_valid && !clr_busy) |=> ($stable(acc) && $stable(cnt) && $stable(filt))); // R2

  AST_CNT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !clr_busy && mode_q == MD_ACCUM && (&cnt)) |=> (&cnt)); // R3

  AST_LPF_CNT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !clr_busy && mode_q == MD_LPF) |=> $stable(cnt)); // R6

  AST_PREV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !soc |=> $stable(prev)); // R9

  AST_PREV_RAW: assert property (@(posedge clk) disable iff (rst)
    (soc && !psel_q) |=> (prev[SAMPLE_W-1:0] == $past(res) &&
                          prev[ACC_W-1:SAMPLE_W] == '0)); // R9

endmodule

bind adc_accum_filter adc_af_checker #(
  .SAMPLE_W (SAMPLE_W),
  .ACC_W    (ACC_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .soc       (soc),
  .res_valid (res_valid),
  .mode_q    (mode_q),
  .psel_q    (psel_q),
  .clr_busy  (clr_busy),
  .acc       (acc_o),
  .cnt       (cnt_o),
  .ovf       (ovf_o),
  .filt      (filt_o),
  .res       (res_o),
  .prev      (prev_o)
);

// File: tb/sim_adc_accum_filter.sv
module sim_adc_accum_filter;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 12;
  localparam int AW = 18;
  localparam int CW = 4;
  localparam longint AMOD = 64'd1 << AW;
  localparam longint CMAX = (64'd1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          soc = 1'b0;
  logic          res_valid = 1'b0;
  logic [SW-1:0] res_data = '0;
  logic          cfg_wr = 1'b0;
  logic [2:0]    cfg_mode = '0;
  logic [2:0]    cfg_shift = '0;
  logic          cfg_psel = 1'b0;
  logic          cfg_clr = 1'b0;
  logic [CW-1:0] rpt_count = '0;
  logic [AW-1:0] acc_o, filt_o, prev_o;
  logic [CW-1:0] cnt_o;
  logic          ovf_o, clr_busy_o;
  logic [SW-1:0] res_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 1'b0;

  // behavioural model state
  longint m_acc, m_cnt, m_ovf, m_filt, m_res, m_prev, m_busy;
  int     m_mode, m_shift, m_psel;

  adc_accum_filter #(.SAMPLE_W(SW), .ACC_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .soc(soc), .res_valid(res_valid), .res_data(res_data),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_shift(cfg_shift), .cfg_psel(cfg_psel),
    .cfg_clr(cfg_clr), .rpt_count(rpt_count), .acc_o(acc_o), .cnt_o(cnt_o),
    .ovf_o(ovf_o), .filt_o(filt_o), .res_o(res_o), .prev_o(prev_o),
    .clr_busy_o(clr_busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge from the inputs of that cycle
  always @(posedge clk) begin
    longint a, c, o, f, full, s, p;
    if (rst) begin
      m_acc = 0; m_cnt = 0; m_ovf = 0; m_filt = 0; m_res = 0; m_prev = 0;
      m_busy = 0; m_mode = 0; m_shift = 0; m_psel = 0;
    end else begin
      a = m_acc; c = m_cnt; o = m_ovf; f = m_filt; s = longint'(res_data);
      p = m_prev;
      if (m_busy != 0) begin
        a = 0; c = 0; o = 0;
      end else if (res_valid) begin
        case (m_mode)
          1: begin
            full = m_acc + s;
            if (full >= AMOD) o = 1;
            a = full % AMOD;
            c = (m_cnt == CMAX) ? m_cnt : m_cnt + 1;
            f = a >> m_shift;
          end
          2, 3: begin
            full = ((m_mode == 3 && m_cnt == 0) ? 0 : m_acc) + s;
            if (full >= AMOD) o = 1;
            if (((m_cnt + 1) % (CMAX + 1)) == longint'(rpt_count)) begin
              f = (full % AMOD) >> m_shift;
              a = 0; c = 0;
            end else begin
              a = full % AMOD; c = m_cnt + 1;
            end
          end
          4: begin
            full = m_acc + s - (m_acc >> m_shift);
            if (full >= AMOD) o = 1;
            a = full % AMOD;
            f = a >> m_shift;
          end
          default: f = s;
        endcase
      end
      if (soc) p = (m_psel != 0) ? m_filt : m_res;
      if (res_valid) m_res = s;
      m_acc = a; m_cnt = c; m_ovf = o; m_filt = f; m_prev = p;
      m_busy = (cfg_wr && cfg_clr) ? 1 : 0;
      if (cfg_wr) begin
        m_mode = int'(cfg_mode); m_shift = int'(cfg_shift); m_psel = int'(cfg_psel);
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      chk("R3 acc vs model", longint'(acc_o), m_acc);
      chk("R4 cnt vs model", longint'(cnt_o), m_cnt);
      chk("R7 ovf vs model", longint'(ovf_o), m_ovf);
      chk("R6 filt vs model", longint'(filt_o), m_filt);
      chk("R2 res vs model", longint'(res_o), m_res);
      chk("R9 prev vs model", longint'(prev_o), m_prev);
      chk("R8 busy vs model", longint'(clr_busy_o), m_busy);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send(input int v, input bit s);
    res_valid = 1'b1; res_data = SW'(v); soc = s;
    tick();
    res_valid = 1'b0; soc = 1'b0;
  endtask

  task automatic wcfg(input int md, input int sh, input bit ps, input bit clr);
    cfg_wr = 1'b1; cfg_mode = 3'(md); cfg_shift = 3'(sh); cfg_psel = ps; cfg_clr = clr;
    tick();
    cfg_wr = 1'b0; cfg_clr = 1'b0;
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    longint expsum;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    chk("R1 acc", acc_o, 0); chk("R1 filt", filt_o, 0); chk("R1 cnt", cnt_o, 0);
    chk("R1 prev", prev_o, 0); chk("R1 busy", clr_busy_o, 0);

    // R1 basic after reset, R2 shift ignored
    wcfg(0, 5, 0, 0);
    send(1234, 0);
    chk("R2 basic filt", filt_o, 1234); chk("R2 basic acc", acc_o, 0);
    wcfg(6, 4, 0, 0);
    send(123, 0);
    chk("R2 reserved filt", filt_o, 123); chk("R2 reserved cnt", cnt_o, 0);

    // R3 accumulate with saturation
    wcfg(1, 2, 0, 0);
    expsum = 0;
    for (int i = 0; i < 20; i++) begin
      send(10 * i + 5, 0);
      expsum += 10 * i + 5;
    end
    chk("R3 acc sum", acc_o, expsum); chk("R3 cnt sat", cnt_o, CMAX);
    chk("R3 filt", filt_o, expsum >> 2);

    // R8 clear, with a sample at the clearing edge
    wcfg(1, 2, 0, 1);
    chk("R8 busy raised", clr_busy_o, 1);
    send(777, 0);
    chk("R8 acc zero", acc_o, 0); chk("R8 cnt zero", cnt_o, 0);
    chk("R8 busy drops", clr_busy_o, 0); chk("R8 filt held", filt_o, expsum >> 2);

    // R4 average
    rpt_count = 4'd4;
    wcfg(2, 2, 0, 0);
    send(100, 0); send(200, 0); send(300, 0);
    chk("R4 partial acc", acc_o, 600); chk("R4 partial cnt", cnt_o, 3);
    chk("R4 filt holds", filt_o, expsum >> 2);
    send(400, 0);
    chk("R4 avg", filt_o, 250); chk("R4 restart acc", acc_o, 0);

    // R6 low-pass settling
    wcfg(4, 3, 0, 0);
    for (int i = 0; i < 200; i++) send(1000, 0);
    chk("R6 settled", filt_o, 1000); chk("R6 cnt untouched", cnt_o, 0);

    // R10 no clear on mode change, R4 adds to leftover
    wcfg(2, 2, 0, 0);
    for (int i = 0; i < 4; i++) send(100, 0);
    chk("R10 R4 leftover avg", filt_o, 2100);

    // R5 burst discards leftover
    wcfg(4, 3, 0, 0);
    for (int i = 0; i < 200; i++) send(1000, 0);
    wcfg(3, 2, 0, 0);
    for (int i = 0; i < 4; i++) send(100, 0);
    chk("R5 burst avg", filt_o, 100);

    // R7 overflow
    wcfg(1, 0, 0, 1);
    tick();
    for (int i = 0; i < 65; i++) send(4095, 0);
    chk("R7 ovf set", ovf_o, 1); chk("R7 wrap", acc_o, 65 * 4095 - AMOD);
    wcfg(0, 0, 0, 0);
    send(5, 0);
    chk("R7 ovf sticky", ovf_o, 1);
    wcfg(0, 0, 0, 1);
    tick();
    chk("R7 R8 ovf cleared", ovf_o, 0);

    // R9 previous-sample, raw then filtered source
    send(300, 0);
    send(50, 1);
    chk("R9 prev raw", prev_o, 300); chk("R9 res", res_o, 50);
    wcfg(1, 1, 1, 1);
    tick();
    send(40, 0);
    send(60, 1);
    chk("R9 prev filt", prev_o, 20); chk("R9 new filt", filt_o, 50);

    // R10 config and sample at the same edge use the old mode
    wcfg(0, 0, 0, 1);
    tick();
    cfg_wr = 1'b1; cfg_mode = 3'd1; res_valid = 1'b1; res_data = 12'd55;
    tick();
    cfg_wr = 1'b0; res_valid = 1'b0;
    chk("R10 old mode acc", acc_o, 0); chk("R10 old mode filt", filt_o, 55);
    send(55, 0);
    chk("R10 new mode acc", acc_o, 55);

    repeat (3) tick();
    finish_run();
  end

endmodule